// File: doc/BRIEF.md
# Size-Proportional Packet Processing Stage

This block stands for the compute step of one node in a chain of packet-handling nodes. A packet descriptor comes in carrying a length field and a routing tag. The stage keeps the descriptor for a number of clock cycles equal to the length times a per-instance unit step. This models a processing time that grows with the amount of data. When the time is up, the stage replaces the length with a post-processing length taken from a generator port. It also overwrites the routing tag with a constant that names the next hop. The result is then presented downstream.

Both sides use valid/ready handshakes. The upstream handshake only completes when the downstream side accepts the result, so the upstream producer gets its acknowledge at the moment of hand-off. Only one descriptor is in the stage at a time. The upstream side must hold its valid and its descriptor stable until that acknowledge.

Top module: `pkt_proc_stage`

## Requirements
- R1: If the stage is idle and `in_valid` is high at a clock edge, processing starts at that edge. `out_valid` rises exactly `in_size*UNIT_STEP` clock edges after the start edge.
- R2: A descriptor with `in_size` equal to 0 produces `out_valid` high after the start edge itself, with no busy cycles.
- R3: A length of `MAX_SIZE` (default 500, so `SIZE_W` is at least 9) with the default unit step runs for the full `MAX_SIZE*UNIT_STEP` cycles. The delay counter never wraps and never ends early.
- R4: `in_ready` is high only in a cycle where `out_valid` and `out_ready` are both high. The hand-off edge does not start a new descriptor, so at most one descriptor is in the stage at a time.
- R5: `out_size` equals the value on `gen_size` at the clock edge where processing completes.
- R6: While `out_valid` is high, `out_tag` equals the parameter `OUT_TAG`, whatever `in_tag` was.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_size` and `out_tag` hold their values into the next cycle.
- R8: A synchronous active-high `rst` returns the stage to idle and drives `out_valid` and `in_ready` low after the next edge, even in the middle of processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream descriptor present |
| in_ready | output | 1 | Acknowledge to upstream, high in the hand-off cycle |
| in_size | input | SIZE_W | Incoming packet length |
| in_tag | input | TAG_W | Incoming routing tag, ignored |
| gen_size | input | SIZE_W | Post-processing length from the generator |
| out_valid | output | 1 | Processed descriptor present |
| out_ready | input | 1 | Downstream accepts the descriptor |
| out_size | output | SIZE_W | Post-processing length |
| out_tag | output | TAG_W | Routing tag, equal to OUT_TAG |

## Verification
The assertions check several things on every cycle: the exact start-to-valid distance, including the zero-length case; the absence of counter wrap during the busy phase; the coupling of the acknowledge to hand-off; the constant tag; output hold under stall; and reset. Two things only the bench's scenarios can show. One is that the length is replaced by the generator value sampled at the completion edge rather than at some other edge. The other is the behaviour across back-to-back descriptors, random stall patterns and a reset during a long busy period.

// File: rtl/pkt_stage_pkg.sv
package pkt_stage_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } stage_state_t;
endpackage

// File: rtl/pkt_step_timer.sv
// Down-counter for the busy phase: loaded with the full cycle budget,
// it flags the last busy cycle when one count remains.
module pkt_step_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_one
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign at_one = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pkt_stage_ctrl.sv
module pkt_stage_ctrl
  import pkt_stage_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         zero_len,
  input  logic         at_one,
  input  logic         out_ready,
  output logic         load,
  output logic         dec,
  output logic         finish,
  output logic         handoff,
  output stage_state_t state_q
);
  stage_state_t state_d;

  always_comb begin
    load    = 1'b0;
    dec     = 1'b0;
    finish  = 1'b0;
    handoff = 1'b0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (zero_len) begin
            finish  = 1'b1;
            state_d = ST_DONE;
          end else begin
            load    = 1'b1;
            state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (at_one) begin
          finish  = 1'b1;
          state_d = ST_DONE;
        end else begin
          dec = 1'b1;
        end
      end
      ST_DONE: begin
        if (out_ready) begin
          handoff = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pkt_desc_rewrite.sv
// Output register: captures the generator length and the fixed tag
// on completion, holds them until hand-off.
module pkt_desc_rewrite #(
  parameter int SIZE_W  = 9,
  parameter int TAG_W   = 2,
  parameter int OUT_TAG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              finish,
  input  logic              handoff,
  input  logic [SIZE_W-1:0] gen_size,
  output logic              out_valid,
  output logic [SIZE_W-1:0] out_size,
  output logic [TAG_W-1:0]  out_tag
);
  localparam logic [TAG_W-1:0] TAG_C = TAG_W'(OUT_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_size  <= '0;
      out_tag   <= '0;
    end else if (finish) begin
      out_valid <= 1'b1;
      out_size  <= gen_size;
      out_tag   <= TAG_C;
    end else if (handoff) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_proc_stage.sv
module pkt_proc_stage
  import pkt_stage_pkg::*;
#(
  parameter int SIZE_W    = 9,
  parameter int TAG_W     = 2,
  parameter int UNIT_STEP = 3,
  parameter int MAX_SIZE  = 500,
  parameter int OUT_TAG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [SIZE_W-1:0] gen_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SIZE_W-1:0] out_size,
  output logic [TAG_W-1:0]  out_tag
);
  localparam int CNT_W = $clog2(MAX_SIZE * UNIT_STEP + 1);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(UNIT_STEP);

  logic             load_w, dec_w, finish_w, handoff_w, at_one_w;
  logic             idle_w;
  logic [CNT_W-1:0] budget_w;
  stage_state_t     state_w;
  logic [TAG_W-1:0] unused_tag;

  assign budget_w   = CNT_W'(in_size) * STEP_C;
  assign idle_w     = (state_w == ST_IDLE);
  assign unused_tag = in_tag;

  pkt_stage_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .zero_len (budget_w == '0),
    .at_one   (at_one_w),
    .out_ready(out_ready),
    .load     (load_w),
    .dec      (dec_w),
    .finish   (finish_w),
    .handoff  (handoff_w),
    .state_q  (state_w)
  );

  pkt_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .load_val(budget_w),
    .dec     (dec_w),
    .at_one  (at_one_w)
  );

  pkt_desc_rewrite #(.SIZE_W(SIZE_W), .TAG_W(TAG_W), .OUT_TAG(OUT_TAG)) u_out (
    .clk      (clk),
    .rst      (rst),
    .finish   (finish_w),
    .handoff  (handoff_w),
    .gen_size (gen_size),
    .out_valid(out_valid),
    .out_size (out_size),
    .out_tag  (out_tag)
  );

  assign in_ready = handoff_w;
endmodule

// File: rtl/pkt_proc_stage_chk.sv
module pkt_proc_stage_chk #(
  parameter int SIZE_W    = 9,
  parameter int TAG_W     = 2,
  parameter int UNIT_STEP = 3,
  parameter int MAX_SIZE  = 500,
  parameter int OUT_TAG   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [SIZE_W-1:0] in_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SIZE_W-1:0] out_size,
  input logic [TAG_W-1:0]  out_tag,
  input logic              idle
);
  localparam int LAT_W = $clog2(MAX_SIZE * UNIT_STEP + 1) + 1;

  logic [LAT_W-1:0] exp_lat, elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_lat <= '0;
      elapsed <= '0;
    end else if (idle && in_valid && !out_valid) begin
      exp_lat <= LAT_W'(in_size) * LAT_W'(UNIT_STEP);
      elapsed <= '0;
    end else if (!out_valid) begin
      elapsed <= elapsed + LAT_W'(1);
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> elapsed == exp_lat);

  a_r2_zero_len: assert property (@(posedge clk) disable iff (rst)
    (idle && in_valid && in_size == '0) |=> out_valid);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (!idle && !out_valid) |-> elapsed < exp_lat);

  a_r4_single_ack: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (!out_valid && idle));

  a_r4_no_early_ack: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !in_ready);

  a_r6_tag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tag == TAG_W'(OUT_TAG));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_size) && $stable(out_tag)));

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));
endmodule

bind pkt_proc_stage pkt_proc_stage_chk #(
  .SIZE_W(SIZE_W), .TAG_W(TAG_W), .UNIT_STEP(UNIT_STEP),
  .MAX_SIZE(MAX_SIZE), .OUT_TAG(OUT_TAG)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_size(in_size), .out_valid(out_valid), .out_ready(out_ready),
  .out_size(out_size), .out_tag(out_tag), .idle(idle_w)
);

// File: tb/pkt_proc_stage_tb.sv
module pkt_proc_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE_W = 9, TAG_W = 2, UNIT_STEP = 3, MAX_SIZE = 500, OUT_TAG = 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [SIZE_W-1:0] in_size = '0, gen_size = '0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic in_ready, out_valid;
  logic [SIZE_W-1:0] out_size;
  logic [TAG_W-1:0]  out_tag;

  int checks = 0, failures = 0, cycle = 0;
  int stall_mode = 0;

  pkt_proc_stage #(.SIZE_W(SIZE_W), .TAG_W(TAG_W), .UNIT_STEP(UNIT_STEP),
                   .MAX_SIZE(MAX_SIZE), .OUT_TAG(OUT_TAG)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_tag(in_tag), .gen_size(gen_size),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_size(out_size), .out_tag(out_tag));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // Reference model: 0 idle, 1 busy, 2 holding a result
  int m_st = 0, m_cnt = 0, m_valid = 0, m_size = 0, m_tag = 0;

  always @(posedge clk) begin
    cycle++;
    if (rst) begin
      m_st = 0; m_valid = 0;
    end else begin
      case (m_st)
        0: if (in_valid) begin
             if (int'(in_size) * UNIT_STEP == 0) begin
               m_st = 2; m_valid = 1; m_size = gen_size; m_tag = OUT_TAG;
             end else begin
               m_st = 1; m_cnt = int'(in_size) * UNIT_STEP;
             end
           end
        1: if (m_cnt == 1) begin
             m_st = 2; m_valid = 1; m_size = gen_size; m_tag = OUT_TAG;
           end else m_cnt--;
        default: if (out_ready) begin m_st = 0; m_valid = 0; end
      endcase
    end
    if (cycle > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Stimulus side: generator length and downstream ready change every cycle
  always @(posedge clk) begin
    #1;
    gen_size <= SIZE_W'((cycle * 37 + 5) % 512);
    if (stall_mode != 0) out_ready <= ($urandom_range(0, 2) == 0);
    else                 out_ready <= 1'b1;
  end

  // Per-cycle comparison against the model
  logic prev_stall = 1'b0;
  logic [SIZE_W-1:0] prev_size = '0;
  logic [TAG_W-1:0]  prev_tag = '0;
  always @(negedge clk) begin
    if (!rst) begin
      check(out_valid == m_valid, "R1 out_valid", out_valid, m_valid);
      check(in_ready == (m_valid != 0 && out_ready), "R4 in_ready", in_ready,
            (m_valid != 0 && out_ready) ? 1 : 0);
      if (m_valid != 0) begin
        check(out_size == m_size, "R5 out_size", out_size, m_size);
        check(out_tag == m_tag, "R6 out_tag", out_tag, m_tag);
      end
      if (prev_stall) begin
        check(out_valid && out_size == prev_size && out_tag == prev_tag,
              "R7 hold", out_size, prev_size);
      end
    end
    prev_stall = !rst && out_valid && !out_ready;
    prev_size  = out_size;
    prev_tag   = out_tag;
  end

  // Issue one descriptor, count low-valid negedges until the result shows
  task automatic send(input int sz, input int tg, input string req);
    int waits = 0;
    @(posedge clk); #1;
    in_valid = 1'b1; in_size = SIZE_W'(sz); in_tag = TAG_W'(tg);
    forever begin
      @(negedge clk);
      if (out_valid) break;
      waits++;
    end
    check(waits == sz * UNIT_STEP + 1, req, waits, sz * UNIT_STEP + 1);
    forever begin
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    check(in_ready == 1'b0, "R8 reset in_ready", in_ready, 0);

    send(0, 1, "R2 zero length");
    send(1, 3, "R1 size 1");
    send(5, 0, "R1 size 5");
    send(100, 2, "R1 size 100");
    send(MAX_SIZE, 1, "R3 max size");
    stall_mode = 1;
    send(7, 3, "R1 size 7 stalled");
    send(0, 0, "R2 zero length stalled");
    send(13, 1, "R1 size 13 stalled");
    stall_mode = 0;

    // reset in the middle of a long busy period
    @(posedge clk); #1;
    in_valid = 1'b1; in_size = SIZE_W'(50);
    repeat (20) @(posedge clk);
    #1 rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 mid-run reset out_valid", out_valid, 0);
    check(in_ready == 1'b0, "R8 mid-run reset in_ready", in_ready, 0);
    repeat (200) @(negedge clk);
    check(out_valid == 1'b0, "R8 aborted descriptor dropped", out_valid, 0);

    send(2, 2, "R1 after reset");
    send(4, 1, "R4 back to back");
    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule